// File: doc/BRIEF.md
# Serial Time-Slot Interchange Switch

This block switches 64 kbit/s channels between eight serial receive lines and eight serial transmit lines. Each line carries a 125 µs frame. The frame holds 32 eight-bit channels sent MSB first at 2.048 Mb/s, and each bit lasts two cycles of the block clock. Every received byte goes into a data memory that has two halves, one for each frame parity. A connection table holds one entry per output channel. The entry names the input line and channel that feed that output channel, so any input channel can reach any output channel and no mapping blocks another.

Each entry also chooses how the output channel behaves:
- Minimum-delay switching sends the byte from the frame in progress if it has already arrived. Otherwise it sends the byte from the previous frame.
- Frame-integrity switching always sends the byte from the previous frame. All channels of a wide data connection therefore leave together.
- Message mode places a byte held in the entry on the line.
- A per-channel drive enable lets the output float. The pad is outside this block; the block gives the enable and the data.

A synchronous register port writes the connection table. The same port reads back the most recent byte of any input channel. Frame alignment comes from an active-high pulse on the frame input.

Top module: `tsi_switch`

## Requirements
- R1: A frame is 512 clocks long. A high `frame_pulse` marks the last clock of a frame, so bit 7 of channel 0 starts on the next clock. Without a pulse the frame counter wraps by itself. Each bit occupies two clocks, and transmit bits change only at the start of a bit.
- R2: Each receive line is sampled on the second clock of every bit, MSB first. The completed byte is stored for its line and channel.
- R3: A table entry is written at `cm_addr` = {output line[7:5], output channel[4:0]}. Its fields are: bits [4:0] source channel, bits [7:5] source line, bit 8 message mode, bit 9 constant delay, bit 10 drive enable. Any source may feed any output.
- R4: With constant delay clear, output channel t of frame F carries source channel s of frame F when s < t, and of frame F-1 when s >= t.
- R5: With constant delay set, output channel t of frame F always carries source channel s of frame F-1, whatever s and t are.
- R6: With message mode set, the output channel carries entry bits [7:0] in place of switched data.
- R7: With drive enable clear, `tx_oe` for that line is low for the whole channel and `tx` is held at 1. `tx_oe` changes only at channel boundaries.
- R8: Reset clears every table entry. All outputs are therefore disabled until the table is written.
- R9: `rd_data` gives, one clock after `rd_addr` = {line[7:5], channel[4:0]}, the latest completed byte of that input channel. That is the byte from the current frame if the channel number is below the channel now being received, and from the previous frame otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_pulse | input | 1 | High on the last clock of a frame |
| rx | input | 8 | Serial receive lines |
| tx | output | 8 | Serial transmit data, 1 when not driven |
| tx_oe | output | 8 | Per-line drive enable for the current channel |
| cm_we | input | 1 | Table write strobe |
| cm_addr | input | 8 | Output line and channel of the entry |
| cm_wdata | input | 11 | Entry contents |
| rd_addr | input | 8 | Input line and channel to read |
| rd_data | output | 8 | Latest byte of the addressed input channel |

## Verification
On every cycle the assertions check the timing skeleton:
- transmit bits hold for both clocks of a bit;
- drive enables change only at channel boundaries;
- the frame pulse realigns the counter and flips the frame parity;
- outputs stay disabled straight after reset.

Only the bench scenarios can show what the switch actually carries. It loads two complete connection tables in turn, each mixing minimum-delay, constant-delay, message and disabled channels. Every byte on all 256 output channels is then compared with the frame and source the bench expects. This sweep also covers the wrap cases where the source channel lies at, before or after the output channel. Processor reads are spread across channels on both sides of the receive position.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int STREAMS = 8,
  parameter int SLOTS   = 32
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      frame_pulse,
  input  logic [STREAMS-1:0]                        rx,
  output logic [STREAMS-1:0]                        tx,
  output logic [STREAMS-1:0]                        tx_oe,
  input  logic                                      cm_we,
  input  logic [$clog2(STREAMS)+$clog2(SLOTS)-1:0]  cm_addr,
  input  logic [$clog2(STREAMS)+$clog2(SLOTS)+2:0]  cm_wdata,
  input  logic [$clog2(STREAMS)+$clog2(SLOTS)-1:0]  rd_addr,
  output logic [7:0]                                rd_data
);
  localparam int SW   = $clog2(STREAMS);
  localparam int CW   = $clog2(SLOTS);
  localparam int AW   = SW + CW;
  localparam int EW   = AW + 3;
  localparam int FCLK = SLOTS * 16;
  localparam int PW   = $clog2(FCLK);

  logic [PW-1:0] cnt;
  logic          par;

  wire          wrap     = frame_pulse || (cnt == PW'(FCLK - 1));
  wire [CW-1:0] cur      = cnt[PW-1:4];
  wire [CW-1:0] nxt      = cur + 1'b1;
  wire          slot_end = &cnt[3:0];
  wire          np       = (nxt == '0) ? ~par : par;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      par <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      par <= par ^ wrap;
    end

  logic [STREAMS-1:0][6:0] rsh;
  logic [7:0]              dmem [2][STREAMS][SLOTS];
  logic [EW-1:0]           cmem [STREAMS*SLOTS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsh <= '0;
    else if (cnt[0])
      for (int j = 0; j < STREAMS; j++) rsh[j] <= {rsh[j][5:0], rx[j]};

  wire [CW-1:0] rc = rd_addr[CW-1:0];
  wire [SW-1:0] rs = rd_addr[AW-1:CW];

  always_ff @(posedge clk) begin
    if (slot_end)
      for (int j = 0; j < STREAMS; j++) dmem[par][j][cur] <= {rsh[j], rx[j]};
    rd_data <= dmem[(rc < cur) ? par : ~par][rs][rc];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < STREAMS*SLOTS; i++) cmem[i] <= '0;
    end else if (cm_we) begin
      cmem[cm_addr] <= cm_wdata;
    end

  for (genvar k = 0; k < STREAMS; k++) begin : g_out
    wire [EW-1:0] e    = cmem[{SW'(k), nxt}];
    wire [SW-1:0] ss   = e[AW-1:CW];
    wire [CW-1:0] sc   = e[CW-1:0];
    wire          bsel = (!e[AW+1] && sc < nxt) ? np : ~np;
    wire [7:0]    src  = (bsel == par && sc == cur) ? {rsh[ss], rx[ss]}
                                                    : dmem[bsel][ss][sc];
    wire [7:0]    byt  = e[AW] ? e[7:0] : src;
    logic [7:0]   sh;
    logic         oe;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sh <= 8'hFF;
        oe <= 1'b0;
      end else if (slot_end) begin
        sh <= byt;
        oe <= e[AW+2];
      end else if (cnt[0]) begin
        sh <= {sh[6:0], 1'b1};
      end

    assign tx[k]    = oe ? sh[7] : 1'b1;
    assign tx_oe[k] = oe;
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int STREAMS = 8,
  parameter int PW      = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_pulse,
  input logic [STREAMS-1:0] tx,
  input logic [STREAMS-1:0] tx_oe,
  input logic [PW-1:0]      cnt,
  input logic               par
);
  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] |-> $stable(tx));

  // R7
  oe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[3:0] != 4'd0) |-> $stable(tx_oe));

  // R1
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_pulse) |-> (cnt == '0));

  // R1
  parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && $past(rst_n)) |-> (par != $past(par)));

  // R8
  reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (tx_oe == '0));
endmodule

bind tsi_switch tsi_switch_chk #(.STREAMS(STREAMS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
  .tx(tx), .tx_oe(tx_oe), .cnt(cnt), .par(par)
);

// File: tb/tsi_switch_bench.sv
`timescale 1ns/1ps
module tsi_switch_bench;
  logic       clk = 0, rst_n = 0, frame_pulse = 0, cm_we = 0;
  logic [7:0] rx = '0, cm_addr = '0, rd_addr = '0;
  logic [10:0] cm_wdata = '0;
  logic [7:0] tx, tx_oe, rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsi_switch u_tsi_switch (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rx(rx),
    .tx(tx), .tx_oe(tx_oe), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_wdata(cm_wdata), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic [7:0] pat(int f, int j, int s);
    return 8'((f * 53 + j * 29 + s * 11 + 7) & 255);
  endfunction

  function automatic [10:0] ent(int cfg, int k, int t);
    if (cfg == 0) begin
      if (t % 8 == 6) return {1'b0, 1'b1, 1'b1, 8'hA5};
      if (t % 8 == 5) return {1'b1, 1'b0, 1'b1, 8'((k * 16 + t) & 255)};
      return {1'b1, 1'((t + k) % 2), 1'b0, 3'((k + 3) % 8), 5'((t * 7 + k) % 32)};
    end
    if (t % 8 == 2) return {1'b0, 1'b0, 1'b0, 8'h3C};
    if (t % 8 == 1) return {1'b1, 1'b1, 1'b1, 8'(~(k * 8 + t))};
    return {1'b1, 1'(t % 3 == 0), 1'b0, 3'(7 - k), 5'(31 - t)};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_slot(int f, int cfg, int k, int t, logic [7:0] got, logic oe);
    logic [10:0] e;
    int ss, sc;
    if (f == 0) begin
      check($sformatf("R8 reset line %0d ch %0d", k, t), {oe, got}, {1'b0, 8'hFF});
      return;
    end
    e = ent(cfg, k, t);
    if (!e[10]) begin
      check($sformatf("R7 disabled line %0d ch %0d", k, t), {oe, got}, {1'b0, 8'hFF});
      return;
    end
    if (e[8]) begin
      check($sformatf("R6 message line %0d ch %0d", k, t), {oe, got}, {1'b1, e[7:0]});
      return;
    end
    ss = int'(e[7:5]);
    sc = int'(e[4:0]);
    if (e[9])
      check($sformatf("R1 R5 constant line %0d ch %0d", k, t), {oe, got}, {1'b1, pat(f - 1, ss, sc)});
    else
      check($sformatf("R2 R3 R4 variable line %0d ch %0d", k, t), {oe, got},
            {1'b1, (sc < t) ? pat(f, ss, sc) : pat(f - 1, ss, sc)});
  endtask

  initial begin
    logic [7:0] gotb [8];
    int rd_exp;
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int g = 0; g < 9 * 512; g++) begin
      int c, f, t, cfg;
      if (g > 0) @(negedge clk);
      c = g % 512;
      f = g / 512;
      t = c / 16;
      cfg = (f < 5) ? 0 : 1;
      if (c % 2 == 0)
        for (int k = 0; k < 8; k++) gotb[k] = {gotb[k][6:0], tx[k]};
      if (c % 16 == 14 && (f == 0 || f == 3 || f == 4 || f == 7 || f == 8))
        for (int k = 0; k < 8; k++) check_slot(f, cfg, k, t, gotb[k], tx_oe[k]);
      if (c % 16 == 9 && (f == 4 || f == 8))
        check($sformatf("R9 read at ch %0d", t), int'(rd_data), rd_exp);
      for (int j = 0; j < 8; j++) rx[j] = pat(f, j, t)[7 - (c / 2) % 8];
      frame_pulse = (c == 511);
      cm_we = 1'b0;
      if ((f == 1 || f == 5) && c < 256) begin
        cm_we = 1'b1;
        cm_addr = 8'(c);
        cm_wdata = ent(cfg, c / 32, c % 32);
      end
      if (c % 16 == 8) begin
        int j, s;
        j = t % 8;
        s = (t * 13 + 5) % 32;
        rd_addr = {3'(j), 5'(s)};
        rd_exp = int'((s < t) ? pat(f, j, s) : pat(f - 1, j, s));
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule